// File: doc/BRIEF.md
# Dual Round-Robin Iterative Crossbar Scheduler

This block computes a one-to-one matching between the N inputs and the N outputs of a crossbar for one time slot. A start pulse loads an N×N matrix of flags, one per virtual output queue, that says which input holds a cell for which output. The block then runs a fixed number of request/grant rounds, one round per clock cycle. In each round, every input that is still unmatched sends a single request. Every output that receives requests grants one of them. Any edge granted in a round becomes part of the matching.

Each input keeps a round-robin request pointer and each output keeps a round-robin grant pointer. The pointers persist from slot to slot. Under steady full load they drift apart, so that every input ends up aiming at a different output. The result is a valid flag and an output index for each input, plus a one-cycle done strobe. These stay on the ports until the next slot is started.

Top module: `drr_xbar_sched`

## Requirements
- R1: A start pulse seen while no slot is running loads req_flat (bit i*N+o set means input i holds a cell for output o) and clears all matches. Every input and output begins the slot unmatched.
- R2: In each round, every unmatched input requests exactly one output. It picks the first still-unmatched output for which it holds a cell, scanning in increasing index order modulo N and starting at its request pointer. An input with no such output sends no request.
- R3: Each output grants the first requesting input, scanning in increasing index order modulo N and starting at its grant pointer. Every grant advances that grant pointer by one, modulo N.
- R4: An input's request pointer advances by one, modulo N, only when its request is granted in the first round of a slot. A grant in a later round leaves it unchanged.
- R5: A slot ends after ITERS rounds, or earlier, after the first round that makes no grant. done is high for exactly one cycle, k cycles after the start edge, where k is the number of rounds run.
- R6: The matching is one-to-one: no input holds two outputs and no output serves two inputs. Every match is a pair whose flag in the loaded matrix is set.
- R7: A start pulse that arrives while a slot is running is ignored, and so is any change of req_flat at that time. The result and the timing of done are unchanged.
- R8: After reset, all pointers are 0, match_valid and match_out are 0, and done is low.
- R9: When every flag is set in every slot, the pointers spread out and every slot produces a full matching of N pairs.
- R10: An empty request matrix produces no matches, with done after one round.
- R11: match_out carries the matched output index of input i in bits i*IW upward, where IW is the pointer width. It reads 0 for an unmatched input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new slot |
| req_flat | input | N*N | Cell-present flags, bit i*N+o for input i and output o |
| match_valid | output | N | Input i is matched |
| match_out | output | N*IW | Matched output index per input |
| done | output | 1 | One-cycle pulse when the matching is final |

## Verification
Two events can land in the same cycle. One is a first-round grant, which moves both the input's request pointer and the output's grant pointer. The other is a second start pulse arriving while the first round is being resolved. The bench raises start again on the cycle right after a slot begins and at the same time replaces the request matrix. It then judges the outcome against an independent pointer model: the matching, the done latency and every later slot must match what the model gives when the extra pulse never happened. Because all pointer state carries on into the following slots, a wrong pointer step in any slot shows up as a mismatch in later results, including the full matching expected under saturated load.

// File: rtl/drr_pkg.sv
package drr_pkg;
  // modulo-n increment used by both pointer families
  function automatic int unsigned rr_next(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // position k steps after ptr on a ring of n
  function automatic int unsigned rr_rot(int unsigned ptr, int unsigned k, int unsigned n);
    return (ptr + k) % n;
  endfunction
endpackage

// File: rtl/drr_rr_pick.sv
module drr_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] ptr,
  output logic          vld,
  output logic [IW-1:0] idx
);
  // scan from the farthest position back so the nearest candidate wins
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand[IW'(drr_pkg::rr_rot(int'(ptr), k, N))]) begin
        vld = 1'b1;
        idx = IW'(drr_pkg::rr_rot(int'(ptr), k, N));
      end
    end
  end

  always_comb begin
    if (vld) a_r2_pick_is_candidate: assert (cand[idx]);
    else     a_r2_none_when_empty:   assert (cand == '0);
  end
endmodule

// File: rtl/drr_iter_ctrl.sv
module drr_iter_ctrl #(
  parameter int ITERS = 3,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          any_grant,
  output logic          slot_load,
  output logic          running,
  output logic          first_iter,
  output logic [CW-1:0] iter,
  output logic          done
);
  logic last_iter;

  assign slot_load  = start && !running;
  assign first_iter = running && (iter == '0);
  assign last_iter  = running && ((iter == CW'(ITERS - 1)) || !any_grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      iter    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (slot_load) begin
        running <= 1'b1;
        iter    <= '0;
      end else if (last_iter) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else if (running) begin
        iter <= iter + 1'b1;
      end
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (iter < CW'(ITERS)));
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !last_iter) |=> (running && iter == $past(iter) + 1'b1));
  a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);
endmodule

// File: rtl/drr_xbar_sched.sv
module drr_xbar_sched #(
  parameter int N     = 8,
  parameter int ITERS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [N*N-1:0]                       req_flat,
  output logic [N-1:0]                         match_valid,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] match_out,
  output logic                                 done
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(ITERS + 1);

  logic [N*N-1:0]        req_q;
  logic [N-1:0]          in_m, out_m;
  logic [IW-1:0]         midx [N];
  logic [IW-1:0]         rp   [N];
  logic [IW-1:0]         gp   [N];

  logic [N-1:0]          rq_vld;
  logic [IW-1:0]         rq_tgt [N];
  logic [N-1:0][N-1:0]   req_col;     // [output][input]
  logic [N-1:0]          gt_vld;
  logic [IW-1:0]         gt_src [N];
  logic [N-1:0][N-1:0]   gnt_to_in;   // [input][output]
  logic [N-1:0]          in_won;
  logic                  any_grant;

  logic                  slot_load, running, first_iter;
  logic [CW-1:0]         iter;

  drr_iter_ctrl #(.ITERS(ITERS), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .any_grant(any_grant),
    .slot_load(slot_load), .running(running), .first_iter(first_iter),
    .iter(iter), .done(done)
  );

  // request side: one picker per input over unmatched outputs it holds cells for
  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0] cand;
    assign cand = req_q[i*N +: N] & ~out_m & {N{running && !in_m[i]}};
    drr_rr_pick #(.N(N), .IW(IW)) u_req (
      .cand(cand), .ptr(rp[i]), .vld(rq_vld[i]), .idx(rq_tgt[i])
    );
    for (genvar o = 0; o < N; o++) begin : g_cross
      assign req_col[o][i]   = rq_vld[i] && (rq_tgt[i] == IW'(o));
      assign gnt_to_in[i][o] = gt_vld[o] && (gt_src[o] == IW'(i));
    end
    assign in_won[i] = |gnt_to_in[i];
    assign match_out[i*IW +: IW] = in_m[i] ? midx[i] : '0;
  end

  // grant side: one picker per output over the inputs requesting it
  for (genvar o = 0; o < N; o++) begin : g_out
    drr_rr_pick #(.N(N), .IW(IW)) u_gnt (
      .cand(req_col[o]), .ptr(gp[o]), .vld(gt_vld[o]), .idx(gt_src[o])
    );
  end

  assign any_grant   = |gt_vld;
  assign match_valid = in_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      in_m  <= '0;
      out_m <= '0;
      for (int i = 0; i < N; i++) begin
        midx[i] <= '0;
        rp[i]   <= '0;
        gp[i]   <= '0;
      end
    end else if (slot_load) begin
      req_q <= req_flat;
      in_m  <= '0;
      out_m <= '0;
      for (int i = 0; i < N; i++) midx[i] <= '0;
    end else if (running) begin
      for (int i = 0; i < N; i++) begin
        if (in_won[i]) begin
          in_m[i] <= 1'b1;
          midx[i] <= rq_tgt[i];
          if (first_iter) rp[i] <= IW'(drr_pkg::rr_next(int'(rp[i]), N));
        end
      end
      for (int o = 0; o < N; o++) begin
        if (gt_vld[o]) begin
          out_m[o] <= 1'b1;
          gp[o]    <= IW'(drr_pkg::rr_next(int'(gp[o]), N));
        end
      end
    end
  end

  a_r6_pair_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_m) == $countones(out_m));
  a_r1_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    slot_load |=> (in_m == '0 && out_m == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk_in
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_to_in[i]));
    a_r6_match_requested: assert property (@(posedge clk) disable iff (!rst_n)
      in_m[i] |-> req_q[i*N + int'(midx[i])]);
    a_r4_rp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(running && !slot_load && in_won[i] && first_iter) |=> $stable(rp[i]));
    a_r2_req_free_out: assert property (@(posedge clk) disable iff (!rst_n)
      rq_vld[i] |-> (!out_m[rq_tgt[i]] && !in_m[i]));
  end

  for (genvar o = 0; o < N; o++) begin : g_chk_out
    a_r3_gp_step: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !slot_load && gt_vld[o]) |=>
        (gp[o] == IW'(drr_pkg::rr_next(int'($past(gp[o])), N))));
  end
endmodule

// File: tb/test_drr_xbar_sched.sv
module test_drr_xbar_sched;
  localparam int N     = 8;
  localparam int ITERS = 3;
  localparam int IW    = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [N*N-1:0]  req_flat = '0;
  logic [N-1:0]    match_valid;
  logic [N*IW-1:0] match_out;
  logic            done;

  int total = 0;
  int bad   = 0;
  int mr [N];
  int mg [N];

  localparam logic [63:0] VEC [8] = '{
    64'h0102040810204080, 64'hFFFFFFFFFFFFFFFF, 64'h00000000000000FF,
    64'h0101010101010101, 64'h8040201008040201, 64'hF0F00F0F3C3CC3C3,
    64'h123456789ABCDEF0, 64'h0000000000000000
  };

  always #2.5 clk = ~clk;

  drr_xbar_sched #(.N(N), .ITERS(ITERS)) i_drr_xbar_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .req_flat(req_flat),
    .match_valid(match_valid), .match_out(match_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent pointer model of one slot
  task automatic model_slot(input logic [63:0] rq, output logic [N-1:0] ev,
                            output logic [N*IW-1:0] eo, output int iters);
    logic [N-1:0] om;
    int rt [N];
    int ng;
    bit stop;
    ev = '0; eo = '0; om = '0; iters = 0; stop = 0;
    for (int it = 0; it < ITERS; it++) begin
      if (!stop) begin
        iters++;
        ng = 0;
        for (int i = 0; i < N; i++) begin
          rt[i] = -1;
          if (!ev[i])
            for (int k = 0; k < N; k++) begin
              int o;
              o = (mr[i] + k) % N;
              if (rt[i] < 0 && rq[i*N + o] && !om[o]) rt[i] = o;
            end
        end
        for (int o = 0; o < N; o++) begin
          bit got;
          got = 0;
          for (int k = 0; k < N; k++) begin
            int i;
            i = (mg[o] + k) % N;
            if (!got && rt[i] == o) begin
              got = 1; ev[i] = 1'b1; eo[i*IW +: IW] = IW'(o); om[o] = 1'b1;
              mg[o] = (mg[o] + 1) % N;
              if (it == 0) mr[i] = (mr[i] + 1) % N;
              ng++;
            end
          end
        end
        if (ng == 0) stop = 1;
      end
    end
  endtask

  task automatic run_slot(input logic [63:0] rq, input bit poke, input string tag);
    logic [N-1:0]    ev;
    logic [N*IW-1:0] eo;
    int iters, lat, pulses;
    logic [N-1:0] seen;
    bit dup;
    model_slot(rq, ev, eo, iters);
    req_flat = rq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0; pulses = 0;
    for (int c = 1; c <= ITERS + 1; c++) begin
      if (c == 1 && poke) begin start = 1'b1; req_flat = ~rq; end
      @(negedge clk);
      start = 1'b0;
      if (done) begin pulses++; if (lat == 0) lat = c; end
    end
    req_flat = rq;
    chk(lat == iters && pulses == 1, "R5", {tag, " done latency"}, 64'(lat), 64'(iters));
    chk(match_valid == ev, "R2 R3 R4", {tag, " match_valid"}, 64'(match_valid), 64'(ev));
    chk(match_out == eo, "R11 R3 R4", {tag, " match_out"}, 64'(match_out), 64'(eo));
    seen = '0; dup = 0;
    for (int i = 0; i < N; i++)
      if (match_valid[i]) begin
        int o;
        o = int'(match_out[i*IW +: IW]);
        if (seen[o] || !rq[i*N + o]) dup = 1;
        seen[o] = 1'b1;
      end
    chk(!dup, "R6", {tag, " one-to-one"}, 64'(match_valid), 64'(ev));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] mv0;
    logic [N*IW-1:0] mo0;
    for (int i = 0; i < N; i++) begin mr[i] = 0; mg[i] = 0; end
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(match_valid == '0 && done == 1'b0, "R8", "reset outputs",
        64'({done, match_valid}), 64'h0);
    chk(match_out == '0, "R8", "reset match_out", 64'(match_out), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R11, pointers carried across slots
    for (int v = 0; v < 8; v++) run_slot(VEC[v], 1'b0, $sformatf("vec%0d", v));

    // R10: empty matrix, one round, no matches
    run_slot(64'h0, 1'b0, "R10 empty");
    chk(match_valid == '0, "R10", "empty gives no match", 64'(match_valid), 64'h0);

    // R7: second start mid-slot with a changed matrix is ignored
    run_slot(64'h00FF00FF00FF00FF, 1'b1, "R7 poke");
    mv0 = match_valid; mo0 = match_out;
    repeat (3) @(negedge clk);
    chk(match_valid == mv0 && match_out == mo0 && !done, "R7", "no restart after poke",
        64'(match_out), 64'(mo0));

    // R1: a new slot clears old matches
    run_slot(64'h0000000000000001, 1'b0, "R1 reload");
    chk(match_valid == 8'h01, "R1", "old matches cleared", 64'(match_valid), 64'h01);

    // R9: saturated load desynchronises pointers
    for (int s = 0; s < 80; s++) run_slot(64'hFFFFFFFFFFFFFFFF, 1'b0, "R9 warm");
    for (int s = 0; s < 10; s++) begin
      run_slot(64'hFFFFFFFFFFFFFFFF, 1'b0, "R9 steady");
      chk(match_valid == 8'hFF, "R9", "full matching", 64'(match_valid), 64'hFF);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule